// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Tracker

This block picks which way of a set-associative cache to replace next. It keeps an approximate recency order for every set as a binary tree. For W ways, where W is a power of two, the tree has W-1 one-bit nodes and log2(W) levels. Each node names the half of its subtree that was used less recently. The victim is found by starting at the root and following each node toward that half until a single way remains.

An update does not read the old tree state. Each node on the path to the touched way is written from the bits of the way number alone. Nodes off that path, and all other sets, keep their values. The cache controller reports each hit with a strobe, the set and the way. On a miss it raises a fill strobe. The tracker then touches the victim of the addressed set, so the newly filled way becomes the most recently used. A separate lookup port returns the current victim of any set at any time.

Top module: `plru_tracker`

## Requirements
- R1: After reset, every node of every set is 0, so the victim of every set is way 0.
- R2: An access to way k writes only the log2(W) nodes on the path from the root to leaf k. Each of these nodes is set to 1 if k lies in the lower half of that node's subtree, and to 0 if k lies in the upper half. With W=8, on a fresh set, an access to way 6 followed by an access to way 0 gives a victim of way 4.
- R3: In the cycle after an access to way k of set s, the victim reported for set s is not k.
- R4: An update changes no other set. Within the touched set, it changes no node off the accessed path.
- R5: When the fill strobe is high and the access strobe is low, the tree of the access set is updated as an access to the current victim of that set (output `fill_way`). In the next cycle that way is no longer the victim.
- R6: When the access and fill strobes are high together, the update uses `acc_way` and the fill request is ignored.
- R7: After accesses to W-1 distinct ways of one set, the victim is neither of the last two ways accessed.
- R8: Victim walk encoding: a node value of 0 steers to the lower child (node 2i+1), and a value of 1 steers to the upper child (node 2i+2). Way bits are produced most significant first, from the root down. The root value is therefore the MSB of the victim.
- R9: Accessing every way of a set once, in ascending order, leaves way 0 as the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_valid | input | 1 | Access strobe: the way in `acc_way` was used |
| fill_valid | input | 1 | Miss strobe: touch the current victim of `acc_set` |
| acc_set | input | log2(NUM_SETS) | Set addressed by the access or fill |
| acc_way | input | log2(NUM_WAYS) | Way that was used |
| look_set | input | log2(NUM_SETS) | Set whose victim is requested |
| victim_way | output | log2(NUM_WAYS) | Current victim of `look_set` |
| fill_way | output | log2(NUM_WAYS) | Current victim of `acc_set`, the way a fill would use |

## Verification
The assertions check several properties on every clock:
- the touched way never becomes the victim of its own set in the next cycle (R3, R5 and R6);
- sets that were not written hold their value (R4);
- the tree comes out of reset cleared (R1);
- the root node always decides the victim's MSB (R8).

Other behaviours depend on the whole history of accesses and can only be shown by the bench scenarios:
- the exact victim after a sequence (R2, R9);
- the guarantee after W-1 distinct accesses (R7);
- that nodes off the path keep their values.

For these the bench runs directed sequences and a long random stream, and compares both victim outputs with its own model on every cycle.

// File: rtl/plru_pkg.sv
package plru_pkg;
  // first heap index of a tree level (root level is 0)
  function automatic int unsigned level_base(input int unsigned lvl);
    return (32'd1 << lvl) - 32'd1;
  endfunction
endpackage

// File: rtl/plru_path_enc.sv
module plru_path_enc #(
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned NODES   = NUM_WAYS - 1
) (
  input  logic [WAY_W-1:0] way,
  output logic [NODES-1:0] node_mask,
  output logic [NODES-1:0] node_val
);
  import plru_pkg::*;

  always_comb begin
    node_mask = '0;
    node_val  = '0;
    for (int unsigned lvl = 0; lvl < WAY_W; lvl++) begin
      int unsigned idx;
      idx = level_base(lvl) + 32'(way >> (WAY_W - lvl));
      node_mask[idx] = 1'b1;
      // the half not containing the way becomes the older one
      node_val[idx]  = ~way[WAY_W-1-lvl];
    end
  end
endmodule

// File: rtl/plru_victim_walk.sv
module plru_victim_walk #(
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned NODES   = NUM_WAYS - 1
) (
  input  logic [NODES-1:0] tree,
  output logic [WAY_W-1:0] way
);
  always_comb begin
    int unsigned node;
    node = 0;
    way  = '0;
    for (int unsigned lvl = 0; lvl < WAY_W; lvl++) begin
      way[WAY_W-1-lvl] = tree[node];
      node = 2 * node + 1 + 32'(tree[node]);
    end
  end
endmodule

// File: rtl/plru_state_array.sv
module plru_state_array #(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned SET_W   = $clog2(NUM_SETS),
  localparam int unsigned NODES   = NUM_WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [NODES-1:0] wr_mask,
  input  logic [NODES-1:0] wr_val,
  input  logic [SET_W-1:0] rd_a_set,
  output logic [NODES-1:0] rd_a_tree,
  input  logic [SET_W-1:0] rd_b_set,
  output logic [NODES-1:0] rd_b_tree
);
  logic [NODES-1:0] tree_q [NUM_SETS];
  logic [NODES-1:0] bit_en [NUM_SETS];

  // next-state: per-bit write enables, no read of old state
  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) begin
      bit_en[s] = (wr_en && wr_set == SET_W'(s)) ? wr_mask : '0;
    end
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    for (genvar b = 0; b < NODES; b++) begin : g_node
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tree_q[s][b] <= 1'b0;
        end else if (bit_en[s][b]) begin
          tree_q[s][b] <= wr_val[b];
        end
      end
    end

    p_other_sets_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_set == SET_W'(s)) |=> $stable(tree_q[s]));

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (tree_q[s] == '0));
  end

  assign rd_a_tree = tree_q[rd_a_set];
  assign rd_b_tree = tree_q[rd_b_set];
endmodule

// File: rtl/plru_tracker.sv
module plru_tracker #(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned SET_W   = $clog2(NUM_SETS),
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned NODES   = NUM_WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             fill_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [SET_W-1:0] look_set,
  output logic [WAY_W-1:0] victim_way,
  output logic [WAY_W-1:0] fill_way
);
  logic [NODES-1:0] acc_tree;
  logic [NODES-1:0] look_tree;
  logic [NODES-1:0] upd_mask;
  logic [NODES-1:0] upd_val;
  logic [WAY_W-1:0] touch_way;
  logic             upd_en;

  // access has priority over a fill in the same cycle
  always_comb begin
    upd_en    = acc_valid | fill_valid;
    touch_way = acc_valid ? acc_way : fill_way;
  end

  plru_path_enc #(.NUM_WAYS(NUM_WAYS)) u_enc (
    .way       (touch_way),
    .node_mask (upd_mask),
    .node_val  (upd_val)
  );

  plru_state_array #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (upd_en),
    .wr_set    (acc_set),
    .wr_mask   (upd_mask),
    .wr_val    (upd_val),
    .rd_a_set  (acc_set),
    .rd_a_tree (acc_tree),
    .rd_b_set  (look_set),
    .rd_b_tree (look_tree)
  );

  plru_victim_walk #(.NUM_WAYS(NUM_WAYS)) u_walk_fill (
    .tree (acc_tree),
    .way  (fill_way)
  );

  plru_victim_walk #(.NUM_WAYS(NUM_WAYS)) u_walk_look (
    .tree (look_tree),
    .way  (victim_way)
  );

  p_no_mru_victim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (acc_set != $past(acc_set) || fill_way != $past(acc_way)));

  p_fill_becomes_mru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !acc_valid) |=> (acc_set != $past(acc_set) || fill_way != $past(fill_way)));

  p_access_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && acc_valid) |=> (acc_set != $past(acc_set) || fill_way != $past(acc_way)));

  p_root_steers_r8: assert property (@(posedge clk) disable iff (!rst_n)
    victim_way[WAY_W-1] == look_tree[0]);
endmodule

// File: tb/plru_tracker_test.sv
`timescale 1ns/1ps
module plru_tracker_test;
  localparam int SETS = 16;
  localparam int W    = 8;
  localparam int SW   = $clog2(SETS);
  localparam int WW   = $clog2(W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, fill_valid = 1'b0;
  logic [SW-1:0] acc_set = '0, look_set = '0;
  logic [WW-1:0] acc_way = '0;
  logic [WW-1:0] victim_way, fill_way;

  int checks = 0;
  int fails  = 0;
  bit model_tree [SETS][W];  // node index 0..W-2 used

  always #2.5 clk = ~clk;

  plru_tracker #(.NUM_SETS(SETS), .NUM_WAYS(W)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .fill_valid(fill_valid),
    .acc_set(acc_set), .acc_way(acc_way), .look_set(look_set),
    .victim_way(victim_way), .fill_way(fill_way)
  );

  // behavioural model: walk by way ranges [lo,hi)
  function automatic int m_victim(input int s);
    int lo = 0, hi = W, n = 0;
    while (hi - lo > 1) begin
      int mid = (lo + hi) / 2;
      if (model_tree[s][n]) begin lo = mid; n = 2*n + 2; end
      else begin hi = mid; n = 2*n + 1; end
    end
    return lo;
  endfunction

  task automatic m_touch(input int s, input int w);
    int lo = 0, hi = W, n = 0;
    while (hi - lo > 1) begin
      int mid = (lo + hi) / 2;
      if (w < mid) begin model_tree[s][n] = 1'b1; hi = mid; n = 2*n + 1; end
      else begin model_tree[s][n] = 1'b0; lo = mid; n = 2*n + 2; end
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare before the edge, then advance the model
  task automatic step(input bit av, input bit fv, input int s, input int w, input int ls,
                      input string req);
    int fv_way;
    @(negedge clk);
    acc_valid = av; fill_valid = fv; acc_set = SW'(s); acc_way = WW'(w); look_set = SW'(ls);
    #1;
    check({req, " victim"}, int'(victim_way), m_victim(ls));
    check({req, " fill_way"}, int'(fill_way), m_victim(s));
    fv_way = m_victim(s);
    @(posedge clk);
    if (av) m_touch(s, w);
    else if (fv) m_touch(s, fv_way);
  endtask

  task automatic idle_look(input int ls, input string req);
    step(1'b0, 1'b0, ls, 0, ls, req);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: all sets start with victim 0
    for (int s = 0; s < SETS; s++) begin
      idle_look(s, "R1");
      check("R1 reset victim", int'(victim_way), 0);
    end

    // R2 / R8: way 6 then way 0 on set 3 gives victim 4
    step(1'b1, 1'b0, 3, 6, 3, "R2");
    idle_look(3, "R2");
    check("R8 after way6 victim", int'(victim_way), 0);
    step(1'b1, 1'b0, 3, 0, 3, "R2");
    idle_look(3, "R2");
    check("R2 way6 then way0", int'(victim_way), 4);

    // R3: accessed way never victim next cycle
    step(1'b1, 1'b0, 2, 0, 2, "R3");
    idle_look(2, "R3");
    check("R3 victim differs", int'(victim_way != 0), 1);

    // R4: set 4 untouched by updates elsewhere
    idle_look(4, "R4");
    check("R4 other set", int'(victim_way), 0);

    // R5: fill touches victim of set 8
    step(1'b0, 1'b1, 8, 0, 8, "R5");
    idle_look(8, "R5");
    check("R5 fill moved victim", int'(victim_way != 0), 1);

    // R6: access and fill together, access way used (set 9 fresh, victim 0)
    step(1'b1, 1'b1, 9, 5, 9, "R6");
    idle_look(9, "R6");
    check("R6 access wins", int'(victim_way), 0);

    // R7: seven distinct ways in set 5
    begin
      int seq [7] = '{7, 2, 5, 0, 3, 6, 1};
      foreach (seq[i]) step(1'b1, 1'b0, 5, seq[i], 5, "R7");
      idle_look(5, "R7");
      check("R7 not last", int'(victim_way != 1), 1);
      check("R7 not second last", int'(victim_way != 6), 1);
    end

    // R9: ascending sweep on set 7
    for (int w = 0; w < W; w++) step(1'b1, 1'b0, 7, w, 7, "R9");
    idle_look(7, "R9");
    check("R9 ascending sweep", int'(victim_way), 0);

    // random stream compared against model every cycle (R2, R4, R5, R6)
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom), 1'($urandom), int'($urandom_range(SETS-1)),
           int'($urandom_range(W-1)), int'($urandom_range(SETS-1)), "R4 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule